// File: doc/BRIEF.md
# SD Card Power Control Sequencer

This block owns the power state of an SD/MMC host port. Software writes a 2-bit power code. The block moves between four states: a reset state with the pads released, power-off with every card line held high, power-cycle with every card line held low, and power-on with the card clock running. In power-cycle the lines are driven low so that the card cannot draw supply current through its clock, command or data pins.

On entry to power-on the block holds the rest of the host disabled while the card clock runs. During this time it drives the command and data lines to their idle-high level. It counts card clock cycles, using the one-cycle enable pulse that the clock divider delivers once per card clock period. After a fixed number of such pulses (74 by default) it raises its warm-up done flag and its host enable. The pads then pass through the command and data path controls of the host core. Leaving power-on drops the enable at once and throws away any partial count.

Top module: `sdpwr_seq`

## Requirements
- R1: Reset state. After reset the power field reads 2'b00. All pad output enables and output values are 0 (released). `host_en` and `warm_done` are 0. This state lasts until the first write.
- R2: A write of code 2'b00 or 2'b01 in `pwr_wdata[1:0]` enters power-off. From the cycle after the write, all pad enables are 1 and all pad values are 1 for the clock, the command line and every data line. `host_en` is 0.
- R3: A write of code 2'b10 enters power-cycle. From the cycle after the write, all pad enables are 1 and all pad values are 0 for the clock, the command line and every data line.
- R4: `pwr_field` returns the code of the last write, including 2'b01, from the cycle after that write.
- R5: While the power code is 2'b11, `pad_ck_oe` is 1 and `pad_ck_out` equals `card_clk`.
- R6: After a write of 2'b11 from any other state, `warm_done` and `host_en` rise in the cycle after the clock edge that samples the 74th `ck_tick` pulse counted in power-on. Before that edge they stay 0.
- R7: The warm-up count ignores `ck_tick` pulses outside power-on. It also ignores a pulse in the same cycle as the write that enters power-on.
- R8: In power-on before warm-up completes, the command and data pads are enabled and driven high, whatever the core path inputs are.
- R9: Once `host_en` is 1, `pad_cmd_oe`, `pad_cmd_out`, `pad_dat_oe` and `pad_dat_out` equal the matching `core_*` inputs.
- R10: A write of 2'b11 while already in power-on neither restarts nor disturbs the warm-up count. An enabled host stays enabled.
- R11: A write of any code other than 2'b11 while in power-on clears `host_en` and `warm_done` from the next cycle. A later entry into power-on needs a full new count of 74 pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwr_wr | input | 1 | Write strobe for the power code |
| pwr_wdata | input | 2 | Power code to write |
| pwr_field | output | 2 | Stored power code |
| ck_tick | input | 1 | One-cycle pulse per card clock period |
| card_clk | input | 1 | Divided card clock level to be sent to the pad |
| core_cmd_oe | input | 1 | Command line enable from the command path |
| core_cmd_out | input | 1 | Command line value from the command path |
| core_dat_oe | input | DAT_W | Data line enables from the data path |
| core_dat_out | input | DAT_W | Data line values from the data path |
| host_en | output | 1 | Enable for the command and data state machines |
| warm_done | output | 1 | Warm-up count complete while in power-on |
| pad_ck_oe | output | 1 | Card clock pad enable |
| pad_ck_out | output | 1 | Card clock pad value |
| pad_cmd_oe | output | 1 | Command pad enable |
| pad_cmd_out | output | 1 | Command pad value |
| pad_dat_oe | output | DAT_W | Data pad enables |
| pad_dat_out | output | DAT_W | Data pad values |

## Verification
The assertions take `ck_tick` to be a synchronous single-cycle pulse. They also take `pwr_wdata` to be meaningful only while `pwr_wr` is high, and the power code to change only through writes. Their own pulse counter starts from the stored code, so they expect no code change between clock edges. The stimulus drives every input at the falling edge. It writes new codes on a sparse random schedule so that warm-up runs both finish and get cut short. It sends tick pulses at random density, including pulses outside power-on and in the entry cycle, and gives the core path inputs fresh random values every cycle.

// File: rtl/sdpwr_pkg.sv
package sdpwr_pkg;

  typedef enum logic [1:0] {
    PS_RESET = 2'd0,
    PS_OFF   = 2'd1,
    PS_CYCLE = 2'd2,
    PS_ON    = 2'd3
  } pwr_state_e;

  localparam logic [1:0] CODE_CYCLE = 2'b10;
  localparam logic [1:0] CODE_ON    = 2'b11;

  // Map a written power code to the state it selects; reserved 01 acts as 00.
  function automatic pwr_state_e code_to_state(input logic [1:0] code);
    case (code)
      CODE_ON:    return PS_ON;
      CODE_CYCLE: return PS_CYCLE;
      default:    return PS_OFF;
    endcase
  endfunction

  // Fixed line level {oe, value} for a state while the host does not own the pads.
  function automatic logic [1:0] fixed_level(input pwr_state_e st);
    case (st)
      PS_OFF:   return 2'b11;
      PS_CYCLE: return 2'b10;
      PS_ON:    return 2'b11;
      default:  return 2'b00;
    endcase
  endfunction

  // Warm-up counter step: hold at zero outside power-on, saturate at the limit.
  function automatic int unsigned warm_step(input int unsigned cnt, input logic on,
                                            input logic tick, input int unsigned limit);
    if (!on)                        return 0;
    else if (tick && (cnt < limit)) return cnt + 1;
    else                            return cnt;
  endfunction

endpackage

// File: rtl/sdpwr_ctrl.sv
module sdpwr_ctrl
  import sdpwr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr,
  input  logic [1:0] wdata,
  output logic [1:0] field,
  output pwr_state_e state,
  output logic       on_entry,
  output logic       on_exit
);

  pwr_state_e next_state;

  assign next_state = wr ? code_to_state(wdata) : state;
  assign on_entry   = (next_state == PS_ON) && (state != PS_ON);
  assign on_exit    = (next_state != PS_ON) && (state == PS_ON);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      field <= 2'b00;
      state <= PS_RESET;
    end else begin
      if (wr) field <= wdata;
      state <= next_state;
    end
  end

endmodule

// File: rtl/sdpwr_warmup.sv
module sdpwr_warmup
  import sdpwr_pkg::*;
#(
  parameter int unsigned WARM_CYCLES = 74
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_on,
  input  logic tick,
  output logic done
);

  localparam int unsigned CNT_W = $clog2(WARM_CYCLES + 1);

  logic [CNT_W-1:0] cnt;
  logic             at_limit;

  assign at_limit = (cnt == CNT_W'(WARM_CYCLES));
  assign done     = in_on && at_limit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= CNT_W'(warm_step(int'(cnt), in_on, tick, WARM_CYCLES));
  end

endmodule

// File: rtl/sdpwr_padmux.sv
module sdpwr_padmux
  import sdpwr_pkg::*;
#(
  parameter int unsigned DAT_W = 8
) (
  input  pwr_state_e       state,
  input  logic             host_own,
  input  logic             card_clk,
  input  logic             core_cmd_oe,
  input  logic             core_cmd_out,
  input  logic [DAT_W-1:0] core_dat_oe,
  input  logic [DAT_W-1:0] core_dat_out,
  output logic             pad_ck_oe,
  output logic             pad_ck_out,
  output logic             pad_cmd_oe,
  output logic             pad_cmd_out,
  output logic [DAT_W-1:0] pad_dat_oe,
  output logic [DAT_W-1:0] pad_dat_out
);

  logic [1:0] lvl;

  assign lvl = fixed_level(state);

  always_comb begin
    pad_ck_oe  = lvl[1];
    pad_ck_out = (state == PS_ON) ? card_clk : lvl[0];
  end

  assign pad_cmd_oe  = host_own ? core_cmd_oe  : lvl[1];
  assign pad_cmd_out = host_own ? core_cmd_out : lvl[0];

  for (genvar i = 0; i < DAT_W; i++) begin : g_dat
    assign pad_dat_oe[i]  = host_own ? core_dat_oe[i]  : lvl[1];
    assign pad_dat_out[i] = host_own ? core_dat_out[i] : lvl[0];
  end

endmodule

// File: rtl/sdpwr_seq.sv
module sdpwr_seq
  import sdpwr_pkg::*;
#(
  parameter int unsigned DAT_W       = 8,
  parameter int unsigned WARM_CYCLES = 74
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwr_wr,
  input  logic [1:0]       pwr_wdata,
  output logic [1:0]       pwr_field,
  input  logic             ck_tick,
  input  logic             card_clk,
  input  logic             core_cmd_oe,
  input  logic             core_cmd_out,
  input  logic [DAT_W-1:0] core_dat_oe,
  input  logic [DAT_W-1:0] core_dat_out,
  output logic             host_en,
  output logic             warm_done,
  output logic             pad_ck_oe,
  output logic             pad_ck_out,
  output logic             pad_cmd_oe,
  output logic             pad_cmd_out,
  output logic [DAT_W-1:0] pad_dat_oe,
  output logic [DAT_W-1:0] pad_dat_out
);

  pwr_state_e state;
  logic       on_entry;
  logic       on_exit;
  logic       in_on;

  sdpwr_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr       (pwr_wr),
    .wdata    (pwr_wdata),
    .field    (pwr_field),
    .state    (state),
    .on_entry (on_entry),
    .on_exit  (on_exit)
  );

  assign in_on = (state == PS_ON);

  sdpwr_warmup #(.WARM_CYCLES(WARM_CYCLES)) u_warm (
    .clk   (clk),
    .rst_n (rst_n),
    .in_on (in_on),
    .tick  (ck_tick),
    .done  (warm_done)
  );

  assign host_en = in_on && warm_done;

  sdpwr_padmux #(.DAT_W(DAT_W)) u_pad (
    .state        (state),
    .host_own     (host_en),
    .card_clk     (card_clk),
    .core_cmd_oe  (core_cmd_oe),
    .core_cmd_out (core_cmd_out),
    .core_dat_oe  (core_dat_oe),
    .core_dat_out (core_dat_out),
    .pad_ck_oe    (pad_ck_oe),
    .pad_ck_out   (pad_ck_out),
    .pad_cmd_oe   (pad_cmd_oe),
    .pad_cmd_out  (pad_cmd_out),
    .pad_dat_oe   (pad_dat_oe),
    .pad_dat_out  (pad_dat_out)
  );

endmodule

// File: rtl/sdpwr_seq_chk.sv
module sdpwr_seq_chk #(
  parameter int unsigned DAT_W       = 8,
  parameter int unsigned WARM_CYCLES = 74
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pwr_wr,
  input logic [1:0]       pwr_wdata,
  input logic [1:0]       pwr_field,
  input logic             ck_tick,
  input logic             card_clk,
  input logic             core_cmd_oe,
  input logic             core_cmd_out,
  input logic [DAT_W-1:0] core_dat_oe,
  input logic [DAT_W-1:0] core_dat_out,
  input logic             host_en,
  input logic             warm_done,
  input logic             pad_ck_oe,
  input logic             pad_ck_out,
  input logic             pad_cmd_oe,
  input logic             pad_cmd_out,
  input logic [DAT_W-1:0] pad_dat_oe,
  input logic [DAT_W-1:0] pad_dat_out,
  input logic             on_entry,
  input logic             on_exit
);

  localparam int unsigned CW = $clog2(WARM_CYCLES + 1);

  // Independent pulse counter driven from the stored code seen at the port.
  logic [CW-1:0] seen;
  logic          code_on;

  assign code_on = (pwr_field == 2'b11);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                   seen <= '0;
    else if (!code_on)                            seen <= '0;
    else if (ck_tick && seen != CW'(WARM_CYCLES)) seen <= seen + CW'(1);
  end

  a_r2_off_high: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_wr && !pwr_wdata[1]) |=> (pad_ck_oe && pad_ck_out && pad_cmd_oe && pad_cmd_out
                                   && (&pad_dat_oe) && (&pad_dat_out) && !host_en));

  a_r3_cycle_low: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_field == 2'b10) |-> (pad_ck_oe && !pad_ck_out && pad_cmd_oe && !pad_cmd_out
                              && (&pad_dat_oe) && (pad_dat_out == '0)));

  a_r5_clock_passes: assert property (@(posedge clk) disable iff (!rst_n)
    code_on |-> (pad_ck_oe && pad_ck_out == card_clk));

  a_r6_enable_needs_count: assert property (@(posedge clk) disable iff (!rst_n)
    host_en |-> (seen == CW'(WARM_CYCLES)));

  a_r6_count_gives_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (code_on && seen == CW'(WARM_CYCLES)) |-> (host_en && warm_done));

  a_r8_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    (code_on && !host_en) |-> (pad_cmd_oe && pad_cmd_out && (&pad_dat_oe) && (&pad_dat_out)));

  a_r9_core_owns: assert property (@(posedge clk) disable iff (!rst_n)
    host_en |-> (pad_cmd_oe == core_cmd_oe && pad_cmd_out == core_cmd_out
                 && pad_dat_oe == core_dat_oe && pad_dat_out == core_dat_out));

  a_r10_rewrite_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (host_en && !(pwr_wr && pwr_wdata != 2'b11)) |=> host_en);

  a_r11_exit_drops: assert property (@(posedge clk) disable iff (!rst_n)
    on_exit |=> (!host_en && !warm_done));

  a_r7_entry_from_zero: assert property (@(posedge clk) disable iff (!rst_n)
    on_entry |=> !warm_done);

endmodule

bind sdpwr_seq sdpwr_seq_chk #(.DAT_W(DAT_W), .WARM_CYCLES(WARM_CYCLES)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .pwr_wr       (pwr_wr),
  .pwr_wdata    (pwr_wdata),
  .pwr_field    (pwr_field),
  .ck_tick      (ck_tick),
  .card_clk     (card_clk),
  .core_cmd_oe  (core_cmd_oe),
  .core_cmd_out (core_cmd_out),
  .core_dat_oe  (core_dat_oe),
  .core_dat_out (core_dat_out),
  .host_en      (host_en),
  .warm_done    (warm_done),
  .pad_ck_oe    (pad_ck_oe),
  .pad_ck_out   (pad_ck_out),
  .pad_cmd_oe   (pad_cmd_oe),
  .pad_cmd_out  (pad_cmd_out),
  .pad_dat_oe   (pad_dat_oe),
  .pad_dat_out  (pad_dat_out),
  .on_entry     (on_entry),
  .on_exit      (on_exit)
);

// File: tb/sdpwr_seq_tb.sv
module sdpwr_seq_tb;

  localparam int DW   = 8;
  localparam int WARM = 74;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          pwr_wr = 1'b0;
  logic [1:0]    pwr_wdata = 2'b00;
  logic [1:0]    pwr_field;
  logic          ck_tick = 1'b0;
  logic          card_clk = 1'b0;
  logic          core_cmd_oe = 1'b0;
  logic          core_cmd_out = 1'b0;
  logic [DW-1:0] core_dat_oe = '0;
  logic [DW-1:0] core_dat_out = '0;
  logic          host_en, warm_done, pad_ck_oe, pad_ck_out, pad_cmd_oe, pad_cmd_out;
  logic [DW-1:0] pad_dat_oe, pad_dat_out;

  int n_run  = 0;
  int n_fail = 0;
  bit ended  = 0;

  // Reference: 0 reset, 1 off, 2 cycle, 3 on
  int          m_st  = 0;
  logic [1:0]  m_fld = 2'b00;
  int          m_cnt = 0;

  always #2 clk = ~clk;

  sdpwr_seq #(.DAT_W(DW), .WARM_CYCLES(WARM)) u_dut (.*);

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic int code_state(input logic [1:0] c);
    return (c == 2'b11) ? 3 : (c == 2'b10) ? 2 : 1;
  endfunction

  function automatic bit m_done();
    return (m_st == 3) && (m_cnt == WARM);
  endfunction

  // Expected {oe,value} of a command/data line in a non-host state
  function automatic logic [1:0] line_lvl(input int st);
    case (st)
      0: return 2'b00;
      2: return 2'b10;
      default: return 2'b11;
    endcase
  endfunction

  task automatic compare_all();
    string tag;
    logic [1:0] l;
    logic [DW-1:0] eoe, eout;
    logic ecoe, ecout;
    l = line_lvl(m_st);
    if (m_done()) begin
      tag = "R9"; ecoe = core_cmd_oe; ecout = core_cmd_out; eoe = core_dat_oe; eout = core_dat_out;
    end else begin
      tag = (m_st == 0) ? "R1" : (m_st == 1) ? "R2" : (m_st == 2) ? "R3" : "R8";
      ecoe = l[1]; ecout = l[0]; eoe = {DW{l[1]}}; eout = {DW{l[0]}};
    end
    check("R6", "host_en", 32'(host_en), 32'(m_done()));
    check("R6", "warm_done", 32'(warm_done), 32'(m_done()));
    check("R4", "pwr_field", 32'(pwr_field), 32'(m_fld));
    check(tag, "cmd pad", 32'({pad_cmd_oe, pad_cmd_out}), 32'({ecoe, ecout}));
    check(tag, "dat pads", {pad_dat_oe, pad_dat_out}, 32'({eoe, eout}));
    if (m_st == 3) check("R5", "ck pad", 32'({pad_ck_oe, pad_ck_out}), 32'({1'b1, card_clk}));
    else           check(tag, "ck pad", 32'({pad_ck_oe, pad_ck_out}), 32'(l));
  endtask

  // One clock: drive at falling edge, advance model at rising edge, compare after it
  task automatic cyc(input logic w, input logic [1:0] d, input logic t);
    @(negedge clk);
    pwr_wr = w; pwr_wdata = d; ck_tick = t;
    card_clk = 1'($urandom);
    core_cmd_oe = 1'($urandom); core_cmd_out = 1'($urandom);
    core_dat_oe = DW'($urandom); core_dat_out = DW'($urandom);
    @(posedge clk);
    if (m_st != 3)             m_cnt = 0;
    else if (t && m_cnt < WARM) m_cnt = m_cnt + 1;
    if (w) begin
      m_fld = d;
      m_st  = code_state(d);
    end
    if (m_st != 3 && w) m_cnt = 0;
    #1;
    compare_all();
  endtask

  task automatic idle_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      cyc(1'b0, 2'b00, 1'b1);
      cyc(1'b0, 2'b00, 1'b0);
    end
  endtask

  initial begin
    void'($urandom(32'h5D0C_A11E));
    #1;
    check("R1", "host_en in reset", 32'(host_en), 0);
    check("R1", "pad enables in reset", 32'({pad_ck_oe, pad_cmd_oe, pad_dat_oe}), 0);
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R1 / R7: ticks in the reset state count for nothing
    for (int i = 0; i < 5; i++) cyc(1'b0, 2'b00, 1'b1);
    check("R1", "field after reset", 32'(pwr_field), 0);
    cyc(1'b1, 2'b00, 1'b0);
    check("R2", "off drives high", 32'({pad_ck_out, pad_cmd_out, pad_dat_out}), 32'h3FF);
    cyc(1'b1, 2'b01, 1'b1);
    check("R2", "reserved code acts as off", 32'({pad_cmd_oe, pad_cmd_out}), 32'h3);
    check("R4", "reserved code reads back", 32'(pwr_field), 32'h1);
    cyc(1'b1, 2'b10, 1'b1);
    check("R3", "cycle drives low", 32'({pad_ck_out, pad_cmd_out, pad_dat_out}), 0);
    idle_ticks(10);
    // R7: the tick in the entry cycle is not counted
    cyc(1'b1, 2'b11, 1'b1);
    idle_ticks(WARM - 1);
    check("R7", "not yet enabled after 73 counted ticks", 32'(host_en), 0);
    cyc(1'b0, 2'b00, 1'b1);
    check("R6", "enabled after 74th tick", 32'(host_en), 1);
    cyc(1'b0, 2'b00, 1'b0);
    // R10: rewriting 11 keeps the host enabled
    cyc(1'b1, 2'b11, 1'b1);
    check("R10", "rewrite of on keeps enable", 32'(host_en), 1);
    // R11: leaving power-on drops the enable, re-entry restarts the count
    cyc(1'b1, 2'b10, 1'b1);
    check("R11", "exit drops enable", 32'({host_en, warm_done}), 0);
    cyc(1'b1, 2'b11, 1'b0);
    idle_ticks(30);
    cyc(1'b1, 2'b11, 1'b1);
    check("R10", "rewrite during warm-up", 32'(host_en), 0);
    cyc(1'b1, 2'b00, 1'b0);
    cyc(1'b1, 2'b11, 1'b0);
    idle_ticks(WARM - 1);
    check("R11", "re-entry needs a full count", 32'(host_en), 0);
    cyc(1'b0, 2'b00, 1'b1);
    check("R11", "re-entry completes at 74", 32'(host_en), 1);
    // Random phase
    for (int i = 0; i < 6000; i++) begin
      logic w;
      w = ($urandom % 60) == 0;
      cyc(w, 2'($urandom), 1'($urandom % 3 != 0));
    end
    if (!ended) begin
      ended = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #(4 * 200000);
    if (!ended) begin
      ended = 1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule